// File: doc/BRIEF.md
# Strobe-Overlap Bytewide Static Memory

This block is a 2048-word by 8-bit static memory driven by three active-low strobes (chip select, write strobe, output strobe) and an 11-bit address. A system clock samples every input. A write is not a single-cycle pulse. It is a window that lasts while chip select and write strobe are both low. The byte is committed to the array only when that window closes, so either strobe can frame the cycle.

The read path and the write path are separate. Read data leaves on a registered output bus. An output-enable flag tells the pad logic when to drive that bus. A lock input from a supply monitor overrides everything else. While it is high, the strobes, address and data are ignored, nothing is written, and the output enable stays low. The block also raises a one-cycle protocol-error pulse when the address moves inside an open write window, and it suppresses that write.

Top module: `strobe_sram`

## Requirements
- R1: The array holds 2048 bytes, addressed by `addr[10:0]`. A byte written to an address is read back unchanged, and other addresses keep their contents.
- R2: A read condition is `we_n`=1, `ce_n`=0, `oe_n`=0 with `lock_i`=0. The array data for the sampled address appears on `dout` with `dout_en`=1 one clock after the condition is sampled, and stays there while the condition holds. `dout_en` falls as soon as the condition goes away. `dout` is 0 whenever `dout_en` is 0.
- R3: A write window is open on every sampled clock with `ce_n`=0 and `we_n`=0. It begins at the later of the two falling strobes and ends at the earlier of the two rising strobes. The write is committed only at the sample that sees the window closed, and either strobe may be the one that ends it.
- R4: The committed byte is the `din` value sampled on the last clock inside the window. Data present on the closing sample is not stored.
- R5: If `addr` differs from the window's opening address on any sample inside the window, `proto_err` is 1 for exactly one cycle after that sample, and the window writes nothing.
- R6: `we_n`=0 forces `dout_en` to 0 at once, even with `ce_n` and `oe_n` both low.
- R7: After a window closes, `we_n` must be sampled high at least once, in the closing sample or a later one, before a new window may write. A window that opens without that recovery writes nothing.
- R8: While `lock_i`=1, `dout_en` is 0 and strobe, address and data activity commits no write.
- R9: A `lock_i` assertion during an open window aborts that window, and the addressed byte keeps its previous value.
- R10: After reset, `dout_en`=0, `dout`=0 and `proto_err`=0.
- R11: The number of writes is unlimited. Repeated writes to one address each take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Supply-monitor lock; blocks all access |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | 11 | Word address |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data, 0 when not enabled |
| dout_en | output | 1 | Drive enable for the external data bus |
| proto_err | output | 1 | One-cycle pulse: address moved inside a write window |

## Verification
The case that is hardest to reach from the ports is a window that opens without recovery. To reach it, the stimulus ends a window by raising chip select while the write strobe stays low, then lowers chip select again before the write strobe ever rises. Only a read-back of the unchanged byte shows that the second window was dropped. The lock cases and the address-change case are checked the same way: the stimulus is driven, then the address is read back after the lock is released or the window is closed, to prove no byte changed. The window-closing tests alternate which strobe rises first. They also change `din` on the closing sample, so a design that commits the closing data fails.

// File: rtl/strobe_sram_pkg.sv
package strobe_sram_pkg;

    localparam int SS_ADDR_W = 11;
    localparam int SS_DATA_W = 8;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_OPEN  = 2'd1,
        W_ABORT = 2'd2
    } win_state_e;

    // Both active-low strobes asserted: the write window is open.
    function automatic logic strobes_overlap(input logic cs_n, input logic wr_n);
        return !cs_n && !wr_n;
    endfunction

    // Read condition on the strobes alone (lock handled by caller).
    function automatic logic read_strobes(input logic cs_n, input logic wr_n, input logic rd_n);
        return !cs_n && !rd_n && wr_n;
    endfunction

endpackage

// File: rtl/ss_window.sv
module ss_window
    import strobe_sram_pkg::*;
#(
    parameter int AW = SS_ADDR_W,
    parameter int DW = SS_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock_i,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          proto_err
);

    win_state_e state;
    logic       rdy;     // write strobe seen high since last window closed
    logic       act;

    assign act   = strobes_overlap(ce_n, we_n) && !lock_i;
    assign wr_en = (state == W_OPEN) && !act && !lock_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= W_IDLE;
            rdy       <= 1'b1;
            proto_err <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            proto_err <= 1'b0;
            if (lock_i) begin
                if (state != W_IDLE) rdy <= 1'b0;
                state <= W_IDLE;
            end else begin
                case (state)
                    W_IDLE: begin
                        if (act) begin
                            if (rdy) begin
                                state   <= W_OPEN;
                                wr_addr <= addr;
                                wr_data <= din;
                            end else begin
                                state <= W_ABORT;
                            end
                        end else if (we_n) begin
                            rdy <= 1'b1;
                        end
                    end
                    W_OPEN: begin
                        if (act) begin
                            if (addr != wr_addr) begin
                                state     <= W_ABORT;
                                proto_err <= 1'b1;
                            end else begin
                                wr_data <= din;
                            end
                        end else begin
                            state <= W_IDLE;
                            rdy   <= we_n;
                        end
                    end
                    W_ABORT: begin
                        if (!act) begin
                            state <= W_IDLE;
                            rdy   <= we_n;
                        end
                    end
                    default: state <= W_IDLE;
                endcase
            end
        end
    end

    // R8: the lock never lets a commit through
    a_r8_lock_no_commit: assert property (@(posedge clk) disable iff (rst)
        lock_i |-> !wr_en);

    // R5: an error pulse always leaves the window in the aborted state
    a_r5_err_aborts: assert property (@(posedge clk) disable iff (rst)
        $rose(proto_err) |-> (state == W_ABORT));

    // R3: a commit happens only once the strobe overlap is gone
    a_r3_commit_on_close: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (ce_n || we_n));

    // R7: a commit requires the window to have been opened from the ready state
    a_r7_commit_needs_open: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(state == W_OPEN || (state == W_IDLE && rdy)));

endmodule

// File: rtl/ss_array.sv
module ss_array
    import strobe_sram_pkg::*;
#(
    parameter int AW = SS_ADDR_W,
    parameter int DW = SS_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_cond,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_data <= mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= rd_cond;
    end

    // R2: valid read data always follows a sampled read condition
    a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_cond));

endmodule

// File: rtl/strobe_sram.sv
module strobe_sram
    import strobe_sram_pkg::*;
#(
    parameter int AW = SS_ADDR_W,
    parameter int DW = SS_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock_i,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          proto_err
);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          rd_cond;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    assign rd_cond = read_strobes(ce_n, we_n, oe_n) && !lock_i;

    ss_window #(.AW(AW), .DW(DW)) u_window (
        .clk       (clk),
        .rst       (rst),
        .lock_i    (lock_i),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .addr      (addr),
        .din       (din),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .proto_err (proto_err)
    );

    ss_array #(.AW(AW), .DW(DW)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_cond  (rd_cond),
        .rd_addr  (addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign dout_en = rd_valid && rd_cond;
    assign dout    = dout_en ? rd_data : '0;

    // R6: write strobe low keeps the bus undriven
    a_r6_we_forces_off: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !dout_en);

    // R8: lock keeps the bus undriven
    a_r8_lock_floats: assert property (@(posedge clk) disable iff (rst)
        lock_i |-> !dout_en);

    // R2: disabled bus reads as zero
    a_r2_zero_when_off: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == '0));

endmodule

// File: tb/strobe_sram_test.sv
`timescale 1ns/1ps
module strobe_sram_test;

    logic        clk = 1'b0;
    logic        rst, lock_i, ce_n, we_n, oe_n;
    logic [10:0] addr;
    logic [7:0]  din;
    logic [7:0]  dout;
    logic        dout_en, proto_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    strobe_sram uut (
        .clk(clk), .rst(rst), .lock_i(lock_i), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .proto_err(proto_err)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    task automatic idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    // mode 0: chip select first, closed by write strobe rising
    // mode 1: write strobe first, closed by chip select rising
    task automatic do_write(logic [10:0] a, logic [7:0] d, int mode);
        addr = a; din = d;
        if (mode == 0) begin
            ce_n = 1'b0; step();
            we_n = 1'b0; step();
            step();
            we_n = 1'b1; step();
            ce_n = 1'b1; step();
        end else begin
            we_n = 1'b0; step();
            ce_n = 1'b0; step();
            step();
            ce_n = 1'b1; step();
            we_n = 1'b1; step();
        end
    endtask

    task automatic do_read(logic [10:0] a, logic [7:0] exp, string tag);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        step();
        check({tag, " en"}, dout_en, 1);
        check({tag, " data"}, dout, exp);
        idle();
        step();
    endtask

    task automatic t_reset();
        check("R10 dout_en", dout_en, 0);
        check("R10 dout", dout, 0);
        check("R10 proto_err", proto_err, 0);
    endtask

    task automatic t_basic();
        do_write(11'h000, 8'h11, 0);
        do_write(11'h7FF, 8'hEE, 1);
        do_write(11'h2A5, 8'h5A, 0);
        do_read(11'h000, 8'h11, "R1 low addr");
        do_read(11'h7FF, 8'hEE, "R1 top addr");
        do_read(11'h2A5, 8'h5A, "R3 mode0 close");
    endtask

    task automatic t_read_timing();
        addr = 11'h7FF; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        check("R2 not yet valid", dout_en, 0);
        check("R2 zero when off", dout, 0);
        step();
        check("R2 valid after one clock", dout_en, 1);
        addr = 11'h000;
        step();
        check("R2 follows address", dout, 8'h11);
        step();
        check("R2 holds", dout_en, 1);
        oe_n = 1'b1; #1;
        check("R2 off when condition drops", dout_en, 0);
        idle(); step();
    endtask

    task automatic t_last_data();
        addr = 11'h123; din = 8'hA1;
        ce_n = 1'b0; we_n = 1'b0; step();
        din = 8'hB2; step();
        din = 8'hC3; step();
        din = 8'hD4; we_n = 1'b1; step();
        idle(); step();
        do_read(11'h123, 8'hC3, "R4 last window data");
    endtask

    task automatic t_addr_change();
        do_write(11'h010, 8'h01, 0);
        do_write(11'h011, 8'h02, 0);
        addr = 11'h010; din = 8'hFF;
        ce_n = 1'b0; we_n = 1'b0; step();
        check("R5 no error yet", proto_err, 0);
        addr = 11'h011; step();
        check("R5 error pulse", proto_err, 1);
        step();
        check("R5 pulse one cycle", proto_err, 0);
        we_n = 1'b1; step();
        idle(); step();
        do_read(11'h010, 8'h01, "R5 first addr unchanged");
        do_read(11'h011, 8'h02, "R5 second addr unchanged");
    endtask

    task automatic t_we_off();
        do_write(11'h040, 8'h77, 1);
        addr = 11'h040; din = 8'h77; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        step();
        check("R6 reading before", dout_en, 1);
        we_n = 1'b0; #1;
        check("R6 write strobe forces off", dout_en, 0);
        step(); step();
        we_n = 1'b1; oe_n = 1'b1; step();
        idle(); step();
    endtask

    task automatic t_recovery();
        addr = 11'h055; din = 8'h3C;
        we_n = 1'b0; step();
        ce_n = 1'b0; step();
        step();
        ce_n = 1'b1; step();        // closes, commits 3C, no recovery seen
        din = 8'hC3; ce_n = 1'b0; step();
        step();
        ce_n = 1'b1; we_n = 1'b1; step();
        idle(); step();
        do_read(11'h055, 8'h3C, "R7 unrecovered window dropped");
        do_write(11'h055, 8'h4D, 0);
        do_read(11'h055, 8'h4D, "R7 write after recovery");
    endtask

    task automatic t_lock();
        do_write(11'h300, 8'h99, 0);
        lock_i = 1'b1;
        addr = 11'h300; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        step(); step();
        check("R8 locked read off", dout_en, 0);
        oe_n = 1'b1;
        do_write(11'h300, 8'h00, 0);
        do_write(11'h300, 8'h01, 1);
        idle(); step();
        lock_i = 1'b0; step();
        do_read(11'h300, 8'h99, "R8 locked writes ignored");
    endtask

    task automatic t_lock_mid();
        do_write(11'h301, 8'h5E, 1);
        addr = 11'h301; din = 8'hE5;
        ce_n = 1'b0; we_n = 1'b0; step(); step();
        lock_i = 1'b1; step();
        we_n = 1'b1; ce_n = 1'b1; step();
        lock_i = 1'b0; step();
        do_read(11'h301, 8'h5E, "R9 lock mid window aborts");
    endtask

    task automatic t_many_writes();
        for (int i = 0; i < 20; i++) begin
            do_write(11'h400, 8'(i * 13 + 7), i % 2);
            do_read(11'h400, 8'(i * 13 + 7), "R11 repeated write");
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst = 1'b1; lock_i = 1'b0; addr = '0; din = '0;
        idle();
        step(); step();
        rst = 1'b0;
        #1;
        t_reset();
        t_basic();
        t_read_timing();
        t_last_data();
        t_addr_change();
        t_we_off();
        t_recovery();
        t_lock();
        t_lock_mid();
        t_many_writes();
        report();
    end

endmodule